// File: doc/BRIEF.md
# Horizontal line timing capture

This block measures six horizontal timing values of a video signal in cycles of a fast measurement clock. All positions are counted from the leading edge of the horizontal sync. The sync input is assumed to be already corrected to positive polarity. Three colour-channel activity detectors, a flyback pulse and a one-cycle strobe that marks the vertical sync leading edge make up the other inputs.

The sync width, line period and the two flyback edges are taken on a single fixed line of each field. That line defaults to the 64th line after the vertical strobe, which keeps the post-equalizing pulses out of the result. Video start and video end are different: they are a running minimum and maximum of the active-video position over every line of the field.

Results build up in working registers. Each vertical strobe copies them into the output registers and then clears them. The outputs therefore stay constant for a whole field and can be read at any time.

Top module: `line_timing_capture`

## Requirements
- R1: The sync, flyback and every video channel input each pass through a two-flop synchroniser, and an edge is found by comparing the current synchronised sample with the previous one. All inputs get the same delay, so each measured value equals the raw distance in cycles between the sync leading edge and the event.
- R2: Sync width is the number of cycles from the sync leading edge to its trailing edge on the capture line. It is 8 bits wide and saturates at 255.
- R3: Line period is the number of cycles from the leading edge that starts the capture line to the next leading edge.
- R4: Flyback start and flyback stop are the positions of the flyback rising edge and falling edge within the capture line.
- R5: The vertical strobe resets the line index to 0, and each sync leading edge after it advances the index by one. The capture line is index CAP_LINE (default 64). Sync and flyback events on any other line leave R2–R4 unchanged. After reset the index sits past the capture line until the first strobe arrives.
- R6: Video start is the smallest position and video end the largest position at which video is active, over all lines since the last strobe. The cycle of a sync leading edge counts as position 0.
- R7: Video counts as active when any one of the colour channels is active.
- R8: If a field has no video, video start reads 4095 and video end reads 0. With no flyback edge on the capture line, flyback start and stop read 4095. With no sync edge on the capture line, sync width and period read 0.
- R9: The position counter saturates at 4095 and does not wrap, so long lines and late events read 4095.
- R10: The outputs change only in the cycle after a vertical strobe. At that point they take the values of the field that just ended, and the working values return to the R8 defaults.
- R11: After reset the outputs read width 0, period 0, flyback start and stop 4095, video start 4095 and video end 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Measurement clock |
| rst | input | 1 | Synchronous active-high reset |
| hsync_i | input | 1 | Horizontal sync, positive polarity, asynchronous |
| flyback_i | input | 1 | Horizontal flyback pulse, asynchronous |
| video_i | input | NCHAN (3) | Per-channel active-video flags, asynchronous |
| vs_lead_i | input | 1 | One-cycle strobe at the vertical sync leading edge, synchronous |
| sync_width_o | output | 8 | Held sync width |
| line_period_o | output | 12 | Held line period |
| fb_start_o | output | 12 | Held flyback start position |
| fb_stop_o | output | 12 | Held flyback stop position |
| vid_first_o | output | 12 | Held earliest active-video position |
| vid_last_o | output | 12 | Held latest active-video position |

## Verification
Four fields are driven, each checked against a behavioural model on every cycle and by explicit expected values after every strobe:
- **Regular field.** Video appears on different channels and one line starts earlier or ends later than the rest. This separates the running minimum and maximum from a last-line value and proves single-channel activity.
- **Field without video or flyback.** The capture line is given a different width and period from its neighbour. This shows that only the capture line is sampled and that the empty-field defaults are produced.
- **Over-long capture line.** Its width, period and late video exceed the counter and width ranges, so saturation is exercised.
- **Field without any sync.** This proves the zero defaults for width and period.

In addition, the held outputs are checked in the middle of a field to confirm they still carry the previous field's values.

// File: rtl/lt_pkg.sv
package lt_pkg;

    localparam int unsigned POS_W = 12;
    localparam int unsigned WID_W = 8;

    typedef logic [POS_W-1:0] pos_t;
    typedef logic [WID_W-1:0] wid_t;

    localparam pos_t POS_MAX   = '1;
    localparam pos_t WID_CEIL  = pos_t'((1 << WID_W) - 1);

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_t;

    typedef struct packed {
        wid_t sync_width;
        pos_t period;
        pos_t fb_start;
        pos_t fb_stop;
        pos_t vid_first;
        pos_t vid_last;
    } meas_t;

    function automatic meas_t meas_idle();
        meas_t m;
        m.sync_width = '0;
        m.period     = '0;
        m.fb_start   = POS_MAX;
        m.fb_stop    = POS_MAX;
        m.vid_first  = POS_MAX;
        m.vid_last   = '0;
        return m;
    endfunction

    function automatic wid_t clip_width(pos_t p);
        return (p > WID_CEIL) ? '1 : p[WID_W-1:0];
    endfunction

endpackage

// File: rtl/lt_sync.sv
module lt_sync #(
    parameter int unsigned W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic stage1, stage2;
        always_ff @(posedge clk) begin
            if (rst) begin
                stage1 <= 1'b0;
                stage2 <= 1'b0;
            end else begin
                stage1 <= d[i];
                stage2 <= stage1;
            end
        end
        assign q[i] = stage2;
    end
endmodule

// File: rtl/lt_edge.sv
module lt_edge
    import lt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  d,
    output edge_t ev
);
    logic lvl;
    logic prev;

    lt_sync #(.W(1)) sync_i (
        .clk (clk),
        .rst (rst),
        .d   (d),
        .q   (lvl)
    );

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= lvl;
    end

    assign ev.rise = lvl & ~prev;
    assign ev.fall = ~lvl & prev;
endmodule

// File: rtl/lt_position.sv
module lt_position
    import lt_pkg::*;
#(
    parameter int unsigned CAP_LINE = 64,
    localparam int unsigned LINE_TOP = CAP_LINE + 1,
    localparam int unsigned LINE_W = $clog2(LINE_TOP + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hs_rise,
    input  logic              vs_lead,
    output pos_t              pos_cnt,
    output pos_t              pos_now,
    output logic [LINE_W-1:0] line_idx,
    output logic              on_cap
);
    localparam logic [LINE_W-1:0] L_TOP = LINE_W'(LINE_TOP);
    localparam logic [LINE_W-1:0] L_CAP = LINE_W'(CAP_LINE);

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_cnt <= '0;
        end else if (hs_rise) begin
            pos_cnt <= pos_t'(1);
        end else if (pos_cnt != POS_MAX) begin
            pos_cnt <= pos_cnt + pos_t'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            line_idx <= L_TOP;
        end else if (vs_lead) begin
            line_idx <= '0;
        end else if (hs_rise && line_idx != L_TOP) begin
            line_idx <= line_idx + 1'b1;
        end
    end

    assign pos_now = hs_rise ? '0 : pos_cnt;
    assign on_cap  = (line_idx == L_CAP);
endmodule

// File: rtl/lt_capture.sv
module lt_capture
    import lt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  vs_lead,
    input  edge_t hs_ev,
    input  edge_t fb_ev,
    input  logic  vid_any,
    input  pos_t  pos_cnt,
    input  pos_t  pos_now,
    input  logic  on_cap,
    output meas_t held
);
    meas_t work;

    always_ff @(posedge clk) begin
        if (rst) begin
            work <= meas_idle();
            held <= meas_idle();
        end else if (vs_lead) begin
            held <= work;
            work <= meas_idle();
        end else begin
            if (on_cap && hs_ev.fall) work.sync_width <= clip_width(pos_cnt);
            if (on_cap && hs_ev.rise) work.period     <= pos_cnt;
            if (on_cap && fb_ev.rise) work.fb_start   <= pos_now;
            if (on_cap && fb_ev.fall) work.fb_stop    <= pos_now;
            if (vid_any && pos_now < work.vid_first) work.vid_first <= pos_now;
            if (vid_any && pos_now > work.vid_last)  work.vid_last  <= pos_now;
        end
    end
endmodule

// File: rtl/line_timing_capture.sv
module line_timing_capture
    import lt_pkg::*;
#(
    parameter int unsigned NCHAN    = 3,
    parameter int unsigned CAP_LINE = 64,
    localparam int unsigned LINE_W  = $clog2(CAP_LINE + 2)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hsync_i,
    input  logic             flyback_i,
    input  logic [NCHAN-1:0] video_i,
    input  logic             vs_lead_i,
    output logic [WID_W-1:0] sync_width_o,
    output logic [POS_W-1:0] line_period_o,
    output logic [POS_W-1:0] fb_start_o,
    output logic [POS_W-1:0] fb_stop_o,
    output logic [POS_W-1:0] vid_first_o,
    output logic [POS_W-1:0] vid_last_o
);
    edge_t             hs_ev, fb_ev;
    logic [NCHAN-1:0]  vid_s;
    logic              vid_any;
    logic              hs_rise;
    pos_t              pos_cnt, pos_now;
    logic [LINE_W-1:0] line_idx;
    logic              on_cap;
    meas_t             held;

    lt_edge hs_edge_i (.clk(clk), .rst(rst), .d(hsync_i),   .ev(hs_ev));
    lt_edge fb_edge_i (.clk(clk), .rst(rst), .d(flyback_i), .ev(fb_ev));

    lt_sync #(.W(NCHAN)) vid_sync_i (
        .clk (clk),
        .rst (rst),
        .d   (video_i),
        .q   (vid_s)
    );

    assign vid_any = |vid_s;
    assign hs_rise = hs_ev.rise;

    lt_position #(.CAP_LINE(CAP_LINE)) pos_i (
        .clk      (clk),
        .rst      (rst),
        .hs_rise  (hs_rise),
        .vs_lead  (vs_lead_i),
        .pos_cnt  (pos_cnt),
        .pos_now  (pos_now),
        .line_idx (line_idx),
        .on_cap   (on_cap)
    );

    lt_capture cap_i (
        .clk     (clk),
        .rst     (rst),
        .vs_lead (vs_lead_i),
        .hs_ev   (hs_ev),
        .fb_ev   (fb_ev),
        .vid_any (vid_any),
        .pos_cnt (pos_cnt),
        .pos_now (pos_now),
        .on_cap  (on_cap),
        .held    (held)
    );

    assign sync_width_o  = held.sync_width;
    assign line_period_o = held.period;
    assign fb_start_o    = held.fb_start;
    assign fb_stop_o     = held.fb_stop;
    assign vid_first_o   = held.vid_first;
    assign vid_last_o    = held.vid_last;
endmodule

// File: rtl/line_timing_checker.sv
module line_timing_checker
    import lt_pkg::*;
#(
    parameter int unsigned CAP_LINE = 64,
    localparam int unsigned LINE_W  = $clog2(CAP_LINE + 2)
) (
    input logic              clk,
    input logic              rst,
    input logic              vs_lead,
    input logic              hs_rise,
    input pos_t              pos_cnt,
    input logic [LINE_W-1:0] line_idx,
    input logic [WID_W-1:0]  sync_width,
    input pos_t              period,
    input pos_t              fb_start,
    input pos_t              fb_stop,
    input pos_t              vid_first,
    input pos_t              vid_last
);
    // R1: counter restarts on a detected sync leading edge
    a_r1_restart: assert property (@(posedge clk) disable iff (rst)
        hs_rise |=> pos_cnt == pos_t'(1));

    // R9: counter holds at its ceiling
    a_r9_saturate: assert property (@(posedge clk) disable iff (rst)
        (!hs_rise && pos_cnt == POS_MAX) |=> pos_cnt == POS_MAX);

    // R9: counter otherwise advances by one
    a_r9_advance: assert property (@(posedge clk) disable iff (rst)
        (!hs_rise && pos_cnt != POS_MAX) |=> pos_cnt == $past(pos_cnt) + pos_t'(1));

    // R5: vertical strobe returns the line index to zero
    a_r5_line_zero: assert property (@(posedge clk) disable iff (rst)
        vs_lead |=> line_idx == '0);

    // R10: held outputs move only after a strobe
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        !vs_lead |=> $stable({sync_width, period, fb_start, fb_stop, vid_first, vid_last}));

    // R6: a field with video has start not after end
    a_r6_order: assert property (@(posedge clk) disable iff (rst)
        (vid_last != '0 || vid_first != POS_MAX) |-> vid_first <= vid_last);
endmodule

bind line_timing_capture line_timing_checker #(.CAP_LINE(CAP_LINE)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .vs_lead    (vs_lead_i),
    .hs_rise    (hs_rise),
    .pos_cnt    (pos_cnt),
    .line_idx   (line_idx),
    .sync_width (sync_width_o),
    .period     (line_period_o),
    .fb_start   (fb_start_o),
    .fb_stop    (fb_stop_o),
    .vid_first  (vid_first_o),
    .vid_last   (vid_last_o)
);

// File: tb/line_timing_capture_tb_top.sv
module line_timing_capture_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CAP       = 64;
    localparam int TOPL      = CAP + 1;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       hs = 1'b0, fb = 1'b0, vs = 1'b0;
    logic [2:0] vid = 3'b000;
    logic [7:0]  o_w;
    logic [11:0] o_p, o_fs, o_fe, o_vf, o_vl;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    line_timing_capture dut_i (
        .clk(clk), .rst(rst), .hsync_i(hs), .flyback_i(fb), .video_i(vid),
        .vs_lead_i(vs), .sync_width_o(o_w), .line_period_o(o_p),
        .fb_start_o(o_fs), .fb_stop_o(o_fe), .vid_first_o(o_vf), .vid_last_o(o_vl)
    );

    task automatic check(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    function automatic int idle_val(int i);
        return (i == 2 || i == 3 || i == 4) ? 4095 : 0;
    endfunction

    int m_cnt, m_line;
    int m_w[6];
    int m_h[6];
    bit hq[$];
    bit fq[$];
    logic [2:0] vq[$];

    always @(posedge clk) begin : model
        bit r, f, fr, ff, va;
        int pos;
        if (rst) begin
            m_cnt = 0;
            m_line = TOPL;
            for (int i = 0; i < 6; i++) begin m_w[i] = idle_val(i); m_h[i] = idle_val(i); end
            hq = '{0, 0, 0};
            fq = '{0, 0, 0};
            vq = '{3'b0, 3'b0, 3'b0};
        end else begin
            r  = hq[1] && !hq[2];
            f  = !hq[1] && hq[2];
            fr = fq[1] && !fq[2];
            ff = !fq[1] && fq[2];
            va = |vq[1];
            pos = r ? 0 : m_cnt;
            if (vs) begin
                m_h = m_w;
                for (int i = 0; i < 6; i++) m_w[i] = idle_val(i);
            end else begin
                if (m_line == CAP && f)  m_w[0] = (m_cnt > 255) ? 255 : m_cnt;
                if (m_line == CAP && r)  m_w[1] = m_cnt;
                if (m_line == CAP && fr) m_w[2] = pos;
                if (m_line == CAP && ff) m_w[3] = pos;
                if (va && pos < m_w[4]) m_w[4] = pos;
                if (va && pos > m_w[5]) m_w[5] = pos;
            end
            m_cnt = r ? 1 : ((m_cnt < 4095) ? m_cnt + 1 : 4095);
            if (vs) m_line = 0;
            else if (r && m_line < TOPL) m_line++;
            hq.push_front(hs);  void'(hq.pop_back());
            fq.push_front(fb);  void'(fq.pop_back());
            vq.push_front(vid); void'(vq.pop_back());
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R2 width (model)",      o_w,  m_h[0]);
            check("R3 period (model)",     o_p,  m_h[1]);
            check("R1 R4 fb start (model)", o_fs, m_h[2]);
            check("R4 fb stop (model)",    o_fe, m_h[3]);
            check("R6 vid first (model)",  o_vf, m_h[4]);
            check("R6 vid last (model)",   o_vl, m_h[5]);
        end
    end

    task automatic run_line(int period, int width, int fbs, int fbe, int v0, int v1, logic [2:0] ch);
        for (int c = 0; c < period; c++) begin
            @(negedge clk);
            hs  = (c < width);
            fb  = (fbs >= 0) && (c >= fbs) && (c < fbe);
            vid = (v0 >= 0 && c >= v0 && c <= v1) ? ch : 3'b000;
        end
    endtask

    task automatic pulse_vs();
        @(negedge clk);
        vs = 1'b1; hs = 1'b0; fb = 1'b0; vid = 3'b000;
        @(negedge clk);
        vs = 1'b0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            finish_run();
        end
    end

    initial begin : stim
        repeat (4) @(negedge clk);
        check("R11 reset width",    o_w,  0);
        check("R11 reset period",   o_p,  0);
        check("R11 reset fb start", o_fs, 4095);
        check("R11 reset fb stop",  o_fe, 4095);
        check("R11 reset vid first", o_vf, 4095);
        check("R11 reset vid last", o_vl, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // field 1: regular lines, channels vary
        pulse_vs();
        for (int ln = 1; ln <= 66; ln++) begin
            if (ln == 5)       run_line(40, 6, 30, 36, 8, 25, 3'b001);
            else if (ln == 20) run_line(40, 6, 30, 36, 10, 28, 3'b100);
            else               run_line(40, 6, 30, 36, 10, 25, 3'b001);
        end
        pulse_vs();
        check("F1 R2 width",        o_w,  6);
        check("F1 R3 period",       o_p,  40);
        check("F1 R1 R4 fb start",  o_fs, 30);
        check("F1 R4 fb stop",      o_fe, 36);
        check("F1 R6 vid first",    o_vf, 8);
        check("F1 R7 vid last blue", o_vl, 28);

        // field 2: no video, no flyback, capture line differs from neighbour
        for (int ln = 1; ln <= 66; ln++) begin
            if (ln == 63)      run_line(40, 10, -1, -1, -1, -1, 3'b000);
            else if (ln == 64) run_line(50, 4, -1, -1, -1, -1, 3'b000);
            else               run_line(40, 6, -1, -1, -1, -1, 3'b000);
            if (ln == 65) begin
                check("F2 R10 held width mid-field",  o_w,  6);
                check("F2 R10 held vid last mid-field", o_vl, 28);
            end
        end
        pulse_vs();
        check("F2 R5 width line 64 only", o_w,  4);
        check("F2 R5 period line 64",     o_p,  50);
        check("F2 R8 no fb start",        o_fs, 4095);
        check("F2 R8 no fb stop",         o_fe, 4095);
        check("F2 R8 no video first",     o_vf, 4095);
        check("F2 R8 no video last",      o_vl, 0);

        // field 3: over-long capture line
        for (int ln = 1; ln <= 66; ln++) begin
            if (ln == 3)       run_line(40, 6, -1, -1, 10, 12, 3'b001);
            else if (ln == 64) run_line(4200, 300, 100, 200, 4150, 4160, 3'b010);
            else               run_line(40, 6, -1, -1, -1, -1, 3'b000);
        end
        pulse_vs();
        check("F3 R2 width clipped",     o_w,  255);
        check("F3 R9 period saturated",  o_p,  4095);
        check("F3 R4 fb start",          o_fs, 100);
        check("F3 R4 fb stop",           o_fe, 200);
        check("F3 R6 vid first",         o_vf, 10);
        check("F3 R9 R7 vid last saturated", o_vl, 4095);

        // field 4: no sync at all
        repeat (300) @(negedge clk);
        pulse_vs();
        check("F4 R8 no sync width",  o_w,  0);
        check("F4 R8 no sync period", o_p,  0);
        check("F4 R8 fb start",       o_fs, 4095);
        check("F4 R8 vid first",      o_vf, 4095);

        repeat (3) @(negedge clk);
        done = 1;
        finish_run();
    end
endmodule